// File: doc/BRIEF.md
# Counter-based random stream controller

This block keeps the running state of a counter-based random number stream and hands out one 32-bit word for each accepted request. The state is a 64-bit key, a 128-bit counter and a 2-bit word index. The block does not compute the keyed bijection itself. Instead it offers the current counter and key on a request/response port, takes back a 128-bit group of four words, buffers the group, and serves those words one at a time. So only one request in four causes a fetch.

Two commands change the state. A load sets the key from a seed and places a subsequence number in the upper half of the counter. A skip moves the counter forward by a 64-bit number of 128-bit groups. Commands and word requests share one idle gate. Nothing new is accepted while a fetch is outstanding. When the block is idle, a load wins over a skip, and a skip wins over a word request.

Top module: `rng_stream_ctrl`

## Requirements
- R1: After reset the key equals the default seed 64'd67280421310721, the counter is zero, the word index is zero, word_valid is low, and both cmd_ready and req_ready are high.
- R2: An accepted load sets key bits 31:0 (key word 0) to seed bits 31:0 and key bits 63:32 to seed bits 63:32. It clears counter bits 63:0, puts the subsequence in counter bits 127:64 (bits 31:0 of the subsequence in word 2, bits 63:32 in word 3), and resets the word index to 0. The new values appear on bij_key and bij_ctr in the cycle after acceptance.
- R3: A request accepted while the index is 0 raises bij_req_valid for exactly the following cycle, with the current counter on bij_ctr and the current key on bij_key. req_ready stays low until the response arrives.
- R4: When bij_rsp_valid is high during an outstanding fetch, the four returned words are stored, word 0 (response bits 31:0) is presented on word_data with word_valid in the next cycle, the index becomes 1, and the counter increases by one.
- R5: A request accepted while the index is k (1 to 3) presents stored word k (response bits 32k+31:32k) in the next cycle without a fetch. The index then advances modulo 4, so the fourth word is followed by a new fetch.
- R6: The counter increment is a full 128-bit +1, and a carry ripples through every 32-bit word up to word 3.
- R7: An accepted skip adds the 64-bit count, zero-extended, to the 128-bit counter, with carries across all four words. It leaves the word index and the stored words unchanged.
- R8: cmd_ready is low while a fetch is outstanding, so loads and skips are held until the response has been taken. When the block is idle, a load takes priority over a skip, and any pending command holds req_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Load command pending |
| load_seed | input | 64 | Seed for the key |
| load_subseq | input | 64 | Subsequence number for the counter upper half |
| skip_valid | input | 1 | Skip command pending |
| skip_count | input | 64 | Number of 128-bit groups to skip |
| cmd_ready | output | 1 | A load or skip is accepted this cycle if valid |
| req_valid | input | 1 | Word request |
| req_ready | output | 1 | Word request accepted this cycle if valid |
| word_valid | output | 1 | word_data holds a served word this cycle |
| word_data | output | 32 | Served random word |
| bij_req_valid | output | 1 | Fetch request to the bijection, one cycle |
| bij_ctr | output | 128 | Current counter (input block to the bijection) |
| bij_key | output | 64 | Current key |
| bij_rsp_valid | input | 1 | Bijection result valid |
| bij_rsp_data | input | 128 | Four result words, word i in bits 32i+31:32i |

## Verification
A load or skip shows on bij_key and bij_ctr one cycle after the clock edge that accepts it. A buffered word shows on word_data one cycle after its request is accepted. A fetch raises bij_req_valid one cycle after acceptance, and its word 0 and the incremented counter appear one cycle after the edge where the response is taken. The bench keeps a behavioural model that it advances on the same rising edge as the design. It compares every output half a period later, once the inputs it drives on the falling edge have settled. Responses come back with zero, one or several cycles of wait, so both the ISSUE and WAIT paths of the fetch are covered.

// File: rtl/rng_stream_pkg.sv
package rng_stream_pkg;

    // Fetch sequencing toward the external bijection
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ISSUE = 2'd1,
        FS_WAIT  = 2'd2
    } fetch_st_e;

endpackage

// File: rtl/rng_lane_adder.sv
// Multi-word adder built from per-lane adders with a rippling carry.
module rng_lane_adder #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LANES  = 4,
    localparam int unsigned CTR_W = WORD_W * LANES
) (
    input  logic [CTR_W-1:0] a,
    input  logic [CTR_W-1:0] b,
    output logic [CTR_W-1:0] sum
);

    logic [LANES-1:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < LANES - 1) begin : g_mid
            logic [WORD_W:0] lane_s;
            assign lane_s = {1'b0, a[i*WORD_W +: WORD_W]}
                          + {1'b0, b[i*WORD_W +: WORD_W]}
                          + (WORD_W+1)'(carry[i]);
            assign sum[i*WORD_W +: WORD_W] = lane_s[WORD_W-1:0];
            assign carry[i+1]              = lane_s[WORD_W];
        end else begin : g_top
            assign sum[i*WORD_W +: WORD_W] = a[i*WORD_W +: WORD_W]
                                           + b[i*WORD_W +: WORD_W]
                                           + WORD_W'(carry[i]);
        end
    end

endmodule

// File: rtl/rng_stream_state.sv
// Key and counter registers with load, skip-ahead and single-step advance.
module rng_stream_state #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LANES  = 4,
    parameter logic [2*WORD_W-1:0] DEFAULT_SEED = 64'd67280421310721,
    localparam int unsigned CTR_W  = WORD_W * LANES,
    localparam int unsigned KEY_W  = 2 * WORD_W,
    localparam int unsigned HALF_W = CTR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_load,
    input  logic [KEY_W-1:0]  seed,
    input  logic [HALF_W-1:0] subseq,
    input  logic              do_skip,
    input  logic [HALF_W-1:0] skip_n,
    input  logic              do_incr,
    output logic [KEY_W-1:0]  key_o,
    output logic [CTR_W-1:0]  ctr_o
);

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [CTR_W-1:0] ctr;
    } st_t;

    st_t st_d, st_q;

    logic [CTR_W-1:0] addend;
    logic [CTR_W-1:0] ctr_sum;

    // Skip and step share the adder; the arbiter above never asserts both
    assign addend = do_skip ? {{HALF_W{1'b0}}, skip_n} : CTR_W'(1);

    rng_lane_adder #(
        .WORD_W (WORD_W),
        .LANES  (LANES)
    ) u_adder (
        .a   (st_q.ctr),
        .b   (addend),
        .sum (ctr_sum)
    );

    always_comb begin
        st_d = st_q;
        if (do_load) begin
            st_d.key = seed;
            st_d.ctr = {subseq, {HALF_W{1'b0}}};
        end else if (do_skip || do_incr) begin
            st_d.ctr = ctr_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.key <= DEFAULT_SEED;
            st_q.ctr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign key_o = st_q.key;
    assign ctr_o = st_q.ctr;

    // R2: load places seed in key and subsequence in the upper counter half
    a_r2_load_fields: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (st_q.key == $past(seed)) &&
                    (st_q.ctr[CTR_W-1:HALF_W] == $past(subseq)) &&
                    (st_q.ctr[HALF_W-1:0] == '0));

    // R6: a single step is a full-width +1
    a_r6_step_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
        (do_incr && !do_load && !do_skip) |=> (st_q.ctr == $past(st_q.ctr) + CTR_W'(1)));

    // R7: skip adds the zero-extended count and keeps the key
    a_r7_skip_add: assert property (@(posedge clk) disable iff (!rst_n)
        (do_skip && !do_load) |=>
            (st_q.ctr == $past(st_q.ctr) + {{HALF_W{1'b0}}, $past(skip_n)}) &&
            $stable(st_q.key));

    // R8: without a command or step the state holds
    a_r8_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_load && !do_skip && !do_incr) |=> $stable(st_q));

endmodule

// File: rtl/rng_word_buf.sv
// Holds one fetched output group and serves it word by word.
module rng_word_buf #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LANES  = 4,
    localparam int unsigned CTR_W = WORD_W * LANES,
    localparam int unsigned IDX_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              fill,
    input  logic [CTR_W-1:0]  fill_data,
    input  logic              serve,
    output logic [IDX_W-1:0]  idx_o,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LANES - 1);

    typedef struct packed {
        logic [LANES-1:0][WORD_W-1:0] words;
        logic [IDX_W-1:0]             idx;
        logic                         vld;
        logic [WORD_W-1:0]            dout;
    } wb_t;

    wb_t wb_d, wb_q;

    always_comb begin
        wb_d     = wb_q;
        wb_d.vld = 1'b0;
        if (clear) begin
            wb_d.idx = '0;
        end else if (fill) begin
            for (int i = 0; i < LANES; i++) begin
                wb_d.words[i] = fill_data[i*WORD_W +: WORD_W];
            end
            wb_d.dout = fill_data[WORD_W-1:0];
            wb_d.idx  = IDX_W'(1);
            wb_d.vld  = 1'b1;
        end else if (serve) begin
            wb_d.dout = wb_q.words[wb_q.idx];
            wb_d.idx  = (wb_q.idx == IDX_LAST) ? '0 : wb_q.idx + IDX_W'(1);
            wb_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else begin
            wb_q <= wb_d;
        end
    end

    assign idx_o      = wb_q.idx;
    assign word_valid = wb_q.vld;
    assign word_data  = wb_q.dout;

    // R5: the last word wraps the index back to zero
    a_r5_idx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && !fill && !clear && wb_q.idx == IDX_LAST) |=> (wb_q.idx == '0));

    // R4: a fill presents the lowest word of the response next cycle
    a_r4_fill_word0: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && !clear) |=> (word_valid && word_data == $past(fill_data[WORD_W-1:0]) &&
                              wb_q.idx == IDX_W'(1)));

    // R7: with no clear, fill or serve, index and stored words stay put
    a_r7_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !fill && !serve) |=> ($stable(wb_q.idx) && $stable(wb_q.words) && !word_valid));

endmodule

// File: rtl/rng_stream_ctrl.sv
// Stream controller: arbitration of commands and word requests, fetch sequencing.
module rng_stream_ctrl #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LANES  = 4,
    parameter logic [2*WORD_W-1:0] DEFAULT_SEED = 64'd67280421310721,
    localparam int unsigned CTR_W  = WORD_W * LANES,
    localparam int unsigned KEY_W  = 2 * WORD_W,
    localparam int unsigned HALF_W = CTR_W / 2,
    localparam int unsigned IDX_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [KEY_W-1:0]  load_seed,
    input  logic [HALF_W-1:0] load_subseq,
    input  logic              skip_valid,
    input  logic [HALF_W-1:0] skip_count,
    output logic              cmd_ready,
    input  logic              req_valid,
    output logic              req_ready,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              bij_req_valid,
    output logic [CTR_W-1:0]  bij_ctr,
    output logic [KEY_W-1:0]  bij_key,
    input  logic              bij_rsp_valid,
    input  logic [CTR_W-1:0]  bij_rsp_data
);

    import rng_stream_pkg::*;

    typedef struct packed {
        fetch_st_e st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             idle;
    logic             load_go;
    logic             skip_go;
    logic             req_go;
    logic             fetch_go;
    logic             serve_go;
    logic             rsp_take;
    logic [IDX_W-1:0] idx;

    // Arbitration: load over skip over word request, all gated by idle
    always_comb begin
        idle      = (ctl_q.st == FS_IDLE);
        cmd_ready = idle;
        req_ready = idle && !load_valid && !skip_valid;
        load_go   = idle && load_valid;
        skip_go   = idle && skip_valid && !load_valid;
        req_go    = req_valid && req_ready;
        fetch_go  = req_go && (idx == '0);
        serve_go  = req_go && (idx != '0);
        rsp_take  = !idle && bij_rsp_valid;
    end

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            FS_IDLE:  if (fetch_go) ctl_d.st = FS_ISSUE;
            FS_ISSUE: ctl_d.st = rsp_take ? FS_IDLE : FS_WAIT;
            FS_WAIT:  if (rsp_take) ctl_d.st = FS_IDLE;
            default:  ctl_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st <= FS_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bij_req_valid = (ctl_q.st == FS_ISSUE);

    rng_stream_state #(
        .WORD_W       (WORD_W),
        .LANES        (LANES),
        .DEFAULT_SEED (DEFAULT_SEED)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_load (load_go),
        .seed    (load_seed),
        .subseq  (load_subseq),
        .do_skip (skip_go),
        .skip_n  (skip_count),
        .do_incr (rsp_take),
        .key_o   (bij_key),
        .ctr_o   (bij_ctr)
    );

    rng_word_buf #(
        .WORD_W (WORD_W),
        .LANES  (LANES)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (load_go),
        .fill       (rsp_take),
        .fill_data  (bij_rsp_data),
        .serve      (serve_go),
        .idx_o      (idx),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    // R3: a fetch starts with a one-cycle request pulse
    a_r3_fetch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |=> bij_req_valid);

    a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        bij_req_valid |=> !bij_req_valid);

    // R8: counter and key frozen while a fetch is outstanding
    a_r8_frozen_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !bij_rsp_valid) |=> ($stable(bij_ctr) && $stable(bij_key)));

    // R4: taking a response yields a word next cycle
    a_r4_rsp_word: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_take |=> word_valid);

    // R5: a buffered request yields a word and no fetch
    a_r5_serve_word: assert property (@(posedge clk) disable iff (!rst_n)
        serve_go |=> (word_valid && !bij_req_valid));

endmodule

// File: tb/tb_rng_stream_ctrl.sv
`timescale 1ns/1ps
module tb_rng_stream_ctrl;

    localparam logic [63:0] DEF_SEED = 64'd67280421310721;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_valid = 1'b0;
    logic [63:0]  load_seed = '0;
    logic [63:0]  load_subseq = '0;
    logic         skip_valid = 1'b0;
    logic [63:0]  skip_count = '0;
    logic         cmd_ready;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         word_valid;
    logic [31:0]  word_data;
    logic         bij_req_valid;
    logic [127:0] bij_ctr;
    logic [63:0]  bij_key;
    logic         bij_rsp_valid = 1'b0;
    logic [127:0] bij_rsp_data = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    rng_stream_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .load_valid(load_valid), .load_seed(load_seed), .load_subseq(load_subseq),
        .skip_valid(skip_valid), .skip_count(skip_count), .cmd_ready(cmd_ready),
        .req_valid(req_valid), .req_ready(req_ready),
        .word_valid(word_valid), .word_data(word_data),
        .bij_req_valid(bij_req_valid), .bij_ctr(bij_ctr), .bij_key(bij_key),
        .bij_rsp_valid(bij_rsp_valid), .bij_rsp_data(bij_rsp_data)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Stand-in bijection: arbitrary mixing, fixed latency
    int rsp_lat = 1;
    bit rsp_pend = 0;
    int rsp_cnt = 0;
    logic [127:0] rsp_hold;

    function automatic logic [127:0] mix(input logic [127:0] c, input logic [63:0] k);
        return {c[63:0] ^ {k[31:0], k[63:32]}, c[127:64] + k} ^ 128'h5A5A_1234_C3C3_8765_0F0F_ABCD_F0F0_0011;
    endfunction

    always @(negedge clk) begin
        bij_rsp_valid = 1'b0;
        if (rsp_pend) begin
            if (rsp_cnt == 0) begin
                bij_rsp_valid = 1'b1;
                bij_rsp_data  = rsp_hold;
                rsp_pend      = 0;
            end else begin
                rsp_cnt--;
            end
        end else if (bij_req_valid) begin
            if (rsp_lat == 0) begin
                bij_rsp_valid = 1'b1;
                bij_rsp_data  = mix(bij_ctr, bij_key);
            end else begin
                rsp_hold = mix(bij_ctr, bij_key);
                rsp_pend = 1;
                rsp_cnt  = rsp_lat - 1;
            end
        end
    end

    // Behavioural reference model
    logic [63:0]  m_key = DEF_SEED;
    logic [127:0] m_ctr = '0;
    int           m_idx = 0;
    int           m_st  = 0;   // 0 idle, 1 request cycle, 2 waiting
    logic [31:0]  m_buf [4];
    bit           m_ev = 0;
    logic [31:0]  m_ew = '0;
    bit           started = 0;

    always @(posedge clk) begin
        m_ev = 0;
        if (!rst_n) begin
            m_key = DEF_SEED; m_ctr = '0; m_idx = 0; m_st = 0;
        end else if (m_st == 0) begin
            if (load_valid) begin
                m_key = load_seed; m_ctr = {load_subseq, 64'h0}; m_idx = 0;
            end else if (skip_valid) begin
                m_ctr = m_ctr + {64'h0, skip_count};
            end else if (req_valid) begin
                if (m_idx == 0) m_st = 1;
                else begin
                    m_ev = 1; m_ew = m_buf[m_idx]; m_idx = (m_idx + 1) % 4;
                end
            end
        end else begin
            if (bij_rsp_valid) begin
                for (int k = 0; k < 4; k++) m_buf[k] = bij_rsp_data[32*k +: 32];
                m_ctr = m_ctr + 128'd1;
                m_ev = 1; m_ew = m_buf[0]; m_idx = 1; m_st = 0;
            end else begin
                m_st = 2;
            end
        end
    end

    always @(negedge clk) begin
        #5;
        if (rst_n && started) begin
            chk("R8 cmd_ready", {127'h0, cmd_ready}, {127'h0, m_st == 0});
            chk("R3 req_ready", {127'h0, req_ready},
                {127'h0, (m_st == 0) && !load_valid && !skip_valid});
            chk("R3 bij_req_valid", {127'h0, bij_req_valid}, {127'h0, m_st == 1});
            chk("R6 counter", bij_ctr, m_ctr);
            chk("R2 key", {64'h0, bij_key}, {64'h0, m_key});
            chk("R4 word_valid", {127'h0, word_valid}, {127'h0, m_ev});
            if (m_ev) chk("R5 word_data", {96'h0, word_data}, {96'h0, m_ew});
        end
    end

    task automatic do_req();
        @(negedge clk); req_valid = 1'b1; #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic do_load(input logic [63:0] s, input logic [63:0] sub);
        @(negedge clk); load_valid = 1'b1; load_seed = s; load_subseq = sub; #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(negedge clk); load_valid = 1'b0;
    endtask

    task automatic do_skip(input logic [63:0] n);
        @(negedge clk); skip_valid = 1'b1; skip_count = n; #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(negedge clk); skip_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1;
        #5;
        // R1 reset state
        chk("R1 key", {64'h0, bij_key}, {64'h0, DEF_SEED});
        chk("R1 counter", bij_ctr, 128'h0);
        chk("R1 word_valid", {127'h0, word_valid}, 128'h0);
        chk("R1 ready", {126'h0, cmd_ready, req_ready}, 128'h3);

        // R3 R4 R5: two full groups, response after two cycles
        rsp_lat = 2;
        for (int i = 0; i < 8; i++) do_req();
        repeat (3) @(negedge clk); #5;
        chk("R6 counter after two groups", bij_ctr, 128'd2);

        // R2 load
        do_load(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210); #5;
        chk("R2 key", {64'h0, bij_key}, {64'h0, 64'h0123_4567_89AB_CDEF});
        chk("R2 counter", bij_ctr, {64'hFEDC_BA98_7654_3210, 64'h0});

        // Same-cycle response path
        rsp_lat = 0;
        for (int i = 0; i < 5; i++) do_req();

        // R6 carry through all words; R7 skip into low half
        rsp_lat = 1;
        do_load(64'hAAAA_5555_0000_FFFF, 64'h0000_0001_FFFF_FFFF);
        do_skip(64'hFFFF_FFFF_FFFF_FFFF); #5;
        chk("R7 skip all ones", bij_ctr, 128'h0000_0001_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF);
        do_req();
        repeat (3) @(negedge clk); #5;
        chk("R6 carry ripple", bij_ctr, 128'h0000_0002_0000_0000_0000_0000_0000_0000);

        // R7 carry from word 0 into word 1
        do_load(64'h1, 64'h0);
        do_skip(64'h0000_0000_FFFF_FFFF);
        do_skip(64'h0000_0001_0000_0001); #5;
        chk("R7 skip carry", bij_ctr, 128'h0000_0002_0000_0000);

        // R7 skip mid-group keeps stored words and index
        do_req(); do_req();
        repeat (2) @(negedge clk);
        do_skip(64'd10); #5;
        chk("R7 mid-group skip", bij_ctr, 128'h0000_0002_0000_000B);
        do_req(); do_req(); #5;
        chk("R7 no fetch for stored words", {127'h0, bij_req_valid}, 128'h0);
        do_req();

        // R8 commands held off during a slow fetch
        rsp_lat = 4;
        do_load(64'h7, 64'h3);
        do_req();
        @(negedge clk); #5;
        chk("R8 cmd_ready low in fetch", {127'h0, cmd_ready}, 128'h0);
        do_load(64'h9, 64'h4); #5;
        chk("R8 load after fetch", bij_ctr, {64'h4, 64'h0});

        // R8 load wins over skip, skip then taken
        @(negedge clk); load_valid = 1'b1; skip_valid = 1'b1;
        load_seed = 64'h55; load_subseq = 64'h66; skip_count = 64'h3;
        @(negedge clk); load_valid = 1'b0; #5;
        chk("R8 load priority", bij_ctr, {64'h66, 64'h0});
        @(negedge clk); skip_valid = 1'b0; #5;
        chk("R8 skip follows", bij_ctr, {64'h66, 64'h3});

        // R8 command blocks a simultaneous word request
        @(negedge clk); req_valid = 1'b1; skip_valid = 1'b1; skip_count = 64'h1; #1;
        chk("R8 req blocked by skip", {127'h0, req_ready}, 128'h0);
        @(negedge clk); skip_valid = 1'b0; #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk); req_valid = 1'b0;
        repeat (8) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule